// File: doc/BRIEF.md
# Time-Division Tuning Data Latch

This block receives tuning data from a controller that shares four data lines over a repeating cycle of four time slots. The block generates the slot strobes itself from a divided clock, with each slot lasting a fixed number of clocks. It samples the lines once per slot, on the final clock of that slot. Three slots each carry one BCD digit of the receive frequency. The fourth slot carries the leading digit and a three-bit operating-mode code.

A load input protects the outputs from data that is still changing. Nothing reaches the output registers until a falling edge on the load input arms the block. After that edge, the block waits for the next whole slot cycle, collects it into a shadow register, and publishes the result at the end of that cycle. A one-clock valid strobe marks the update. Between updates the outputs hold their value, whatever the data lines do.

Top module: `tuning_data_latch`

## Requirements
- R1: `slot_o` is one-hot. It steps T1 (bit 0), T2 (bit 1), T3 (bit 2), T4 (bit 3) and wraps back to T1, with each slot lasting SLOT_LEN clocks. The data lines are sampled on the last clock of each slot.
- R2: The slots T1, T2 and T3 carry the units, tens and hundreds BCD digit, in that order. Within each digit, `data_i[0]` is the least significant bit. The digits appear at `freq_o[3:0]`, `freq_o[7:4]` and `freq_o[11:8]`.
- R3: In slot T4, `data_i[0]` is the leading frequency digit, which can only be 0 or 1, and it appears at `freq_o[12]`. In the same slot, `data_i[3:1]` is the mode code, and it appears at `mode_o[2:0]`.
- R4: `fm_o` is high exactly when `mode_o` equals 3'b001. Every other code counts as AM.
- R5: A falling edge of `ld_i` arms a capture. The outputs then update at the end of the first complete T1-to-T4 cycle that starts after the edge. Counted from the falling edge, this is between 4*SLOT_LEN+1 and 8*SLOT_LEN clocks later.
- R6: `valid_o` is high for exactly one clock, in the same clock in which the new word first appears on the outputs.
- R7: If no falling edge of `ld_i` occurs, changing the data lines leaves `freq_o`, `mode_o` and `fm_o` unchanged, and `valid_o` stays low.
- R8: A new falling edge of `ld_i` during a collection abandons that collection and restarts the wait for a fresh cycle. Only the word from the restarted collection is published.
- R9: During and right after reset, `slot_o` shows T1, the word outputs are zero and `valid_o` is low.
- R10: A rising edge of `ld_i`, or `ld_i` held high, does not arm a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_i | input | 1 | Load qualifier; its falling edge arms a capture |
| data_i | input | 4 | Time-shared data lines, bit 0 = line A |
| slot_o | output | 4 | One-hot slot strobes, bit 0 = T1 |
| freq_o | output | 13 | Leading bit plus three BCD digits |
| mode_o | output | 3 | Mode code from slot T4 |
| fm_o | output | 1 | High when the mode code selects FM |
| valid_o | output | 1 | One-clock pulse when the outputs update |

## Verification
The hardest case to reach from the ports is a second load edge that lands inside an active collection, while the first frame's digits are already half-sampled. Reaching it needs a deliberate alignment to the slot phase. The bench watches `slot_o`, starts the first load inside T4 so that collection begins on the next T1, and then fires the second load while T3 of that collection is showing. The lines are switched to a different frame at the same moment. Only a design that really abandons the first collection emits exactly one strobe, and that strobe carries the second frame.

// File: rtl/tdl_pkg.sv
package tdl_pkg;

    localparam int NSLOT  = 4;
    localparam int DIG_W  = 4;
    localparam int NDIG   = 3;
    localparam int MODE_W = 3;
    localparam int DATA_W = 4;
    localparam int FREQ_W = NDIG * DIG_W + 1;

    localparam logic [MODE_W-1:0] MODE_FM = 3'b001;

    typedef logic [DIG_W-1:0] bcd_t;
    typedef logic [1:0]       slot_idx_t;

    localparam slot_idx_t LAST_SLOT = slot_idx_t'(NSLOT - 1);

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_WAIT    = 2'd1,
        PH_COLLECT = 2'd2
    } phase_e;

    typedef struct packed {
        logic              lead;
        bcd_t [NDIG-1:0]   dig;
    } freq_word_t;

    typedef struct packed {
        freq_word_t        freq;
        logic [MODE_W-1:0] mode;
    } tune_word_t;

    function automatic logic [NSLOT-1:0] slot_onehot(input slot_idx_t i);
        return NSLOT'(1) << i;
    endfunction

    function automatic slot_idx_t slot_after(input slot_idx_t i);
        return slot_idx_t'(i + 2'd1);
    endfunction

    function automatic logic is_fm(input logic [MODE_W-1:0] m);
        return m == MODE_FM;
    endfunction

endpackage

// File: rtl/tdl_slot_gen.sv
module tdl_slot_gen
    import tdl_pkg::*;
#(
    parameter int SLOT_LEN = 4
) (
    input  logic             clk,
    input  logic             rst,
    output slot_idx_t        idx_o,
    output logic [NSLOT-1:0] strobe_o,
    output logic             sample_o,
    output logic             start_o
);
    localparam int CW = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(SLOT_LEN - 1);

    logic [CW-1:0] cnt_q;
    slot_idx_t     idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            idx_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
            idx_q <= slot_after(idx_q);
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign idx_o    = idx_q;
    assign strobe_o = slot_onehot(idx_q);
    assign sample_o = (cnt_q == CNT_LAST);
    assign start_o  = (cnt_q == '0) && (idx_q == '0);

    p_slot_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $countones(strobe_o) == 1);

    p_slot_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !sample_o |=> $stable(strobe_o));

    p_slot_step_r1: assert property (@(posedge clk) disable iff (rst)
        sample_o |=> !$stable(strobe_o));

endmodule

// File: rtl/tdl_load_edge.sv
module tdl_load_edge (
    input  logic clk,
    input  logic rst,
    input  logic ld_i,
    output logic fall_o
);
    logic ld_q;

    always_ff @(posedge clk) begin
        if (rst) ld_q <= 1'b0;
        else     ld_q <= ld_i;
    end

    assign fall_o = ld_q & ~ld_i;

    p_fall_needs_low_r10: assert property (@(posedge clk) disable iff (rst)
        ld_i |-> !fall_o);

endmodule

// File: rtl/tdl_frame_ctrl.sv
module tdl_frame_ctrl
    import tdl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fall_i,
    input  logic              start_i,
    input  logic              sample_i,
    input  slot_idx_t         idx_i,
    input  logic [DATA_W-1:0] data_i,
    output tune_word_t        word_o,
    output logic              valid_o
);
    phase_e          ph_q;
    bcd_t [NDIG-1:0] shadow_q;
    tune_word_t      word_q;
    logic            valid_q;
    logic            commit;

    assign commit = (ph_q == PH_COLLECT) && sample_i && (idx_i == LAST_SLOT) && !fall_i;

    for (genvar g = 0; g < NDIG; g++) begin : g_digit
        always_ff @(posedge clk) begin
            if (rst)
                shadow_q[g] <= '0;
            else if (sample_i && idx_i == slot_idx_t'(g))
                shadow_q[g] <= data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= PH_IDLE;
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= commit;
            if (commit) begin
                word_q.freq.dig  <= shadow_q;
                word_q.freq.lead <= data_i[0];
                word_q.mode      <= data_i[DATA_W-1:1];
            end
            if (fall_i) begin
                ph_q <= PH_WAIT;
            end else begin
                unique case (ph_q)
                    PH_WAIT:    if (start_i) ph_q <= PH_COLLECT;
                    PH_COLLECT: if (commit)  ph_q <= PH_IDLE;
                    default:    ph_q <= PH_IDLE;
                endcase
            end
        end
    end

    assign word_o  = word_q;
    assign valid_o = valid_q;

    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);

    p_valid_after_collect_r5: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> $past(ph_q == PH_COLLECT));

    p_rearm_r8: assert property (@(posedge clk) disable iff (rst)
        fall_i |=> (ph_q == PH_WAIT) && !valid_q);

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_IDLE) |=> !valid_q);

endmodule

// File: rtl/tuning_data_latch.sv
module tuning_data_latch
    import tdl_pkg::*;
#(
    parameter int SLOT_LEN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [NSLOT-1:0]  slot_o,
    output logic [FREQ_W-1:0] freq_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              fm_o,
    output logic              valid_o
);
    slot_idx_t  idx;
    logic       sample;
    logic       start;
    logic       fall;
    tune_word_t word;

    tdl_slot_gen #(.SLOT_LEN(SLOT_LEN)) slot_gen_i (
        .clk      (clk),
        .rst      (rst),
        .idx_o    (idx),
        .strobe_o (slot_o),
        .sample_o (sample),
        .start_o  (start)
    );

    tdl_load_edge load_edge_i (
        .clk    (clk),
        .rst    (rst),
        .ld_i   (ld_i),
        .fall_o (fall)
    );

    tdl_frame_ctrl frame_ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .fall_i   (fall),
        .start_i  (start),
        .sample_i (sample),
        .idx_i    (idx),
        .data_i   (data_i),
        .word_o   (word),
        .valid_o  (valid_o)
    );

    assign freq_o = word.freq;
    assign mode_o = word.mode;
    assign fm_o   = is_fm(word.mode);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> $stable(freq_o) && $stable(mode_o));

    p_fm_flag_r4: assert property (@(posedge clk) disable iff (rst)
        fm_o == (mode_o == 3'b001));

endmodule

// File: tb/tuning_data_latch_tb.sv
module tuning_data_latch_tb_top;

    localparam int SL  = 4;
    localparam int CYC = 4 * SL;

    logic        clk = 1'b0;
    logic        rst;
    logic        ld;
    logic [3:0]  data;
    logic [3:0]  slot_o;
    logic [12:0] freq_o;
    logic [2:0]  mode_o;
    logic        fm_o;
    logic        valid_o;

    logic        f_lead;
    logic [3:0]  f_units, f_tens, f_hund;
    logic [2:0]  f_mode;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    tuning_data_latch #(.SLOT_LEN(SL)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .ld_i    (ld),
        .data_i  (data),
        .slot_o  (slot_o),
        .freq_o  (freq_o),
        .mode_o  (mode_o),
        .fm_o    (fm_o),
        .valid_o (valid_o)
    );

    // Controller model: lines follow the current slot (T4: A = lead, B..D = mode)
    always_comb begin
        case (slot_o)
            4'b0001: data = f_units;
            4'b0010: data = f_tens;
            4'b0100: data = f_hund;
            4'b1000: data = {f_mode, f_lead};
            default: data = 4'h0;
        endcase
    end

    // {lead, hundreds, tens, units, mode}
    localparam logic [15:0] VEC [6] = '{
        {1'b0, 4'd8, 4'd7, 4'd5, 3'b001},
        {1'b1, 4'd0, 4'd8, 4'd0, 3'b001},
        {1'b0, 4'd9, 4'd8, 4'd1, 3'b001},
        {1'b0, 4'd5, 4'd3, 4'd1, 3'b010},
        {1'b1, 4'd6, 4'd0, 4'd2, 3'b010},
        {1'b0, 4'd9, 4'd9, 4'd9, 3'b100}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_frame(input logic [15:0] v);
        {f_lead, f_hund, f_tens, f_units, f_mode} = v;
    endtask

    task automatic pulse_load();
        @(negedge clk) ld = 1'b1;
        @(negedge clk) ld = 1'b0;
    endtask

    task automatic wait_valid(output int lat);
        lat = 0;
        while (!valid_o && lat < 3 * CYC) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic wait_slot_entry(input logic [3:0] s);
        do @(negedge clk); while (slot_o == s);
        while (slot_o != s) @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int          lat;
        int          vcount;
        logic [12:0] keep_f;
        logic [2:0]  keep_m;
        logic        saw;

        rst = 1'b1;
        ld  = 1'b0;
        set_frame(16'h0);
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 slot", 32'(slot_o), 32'h1);
        chk("R9 freq", 32'(freq_o), 32'h0);
        chk("R9 valid", 32'(valid_o), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 after-release valid", 32'(valid_o), 32'h0);
        chk("R9 after-release freq", 32'(freq_o), 32'h0);

        // R1: slot rotation, SL clocks per slot
        wait_slot_entry(4'b0001);
        for (int s = 0; s < 8; s++) begin
            for (int k = 0; k < SL; k++) begin
                chk("R1 slot strobe", 32'(slot_o), 32'(4'b0001 << (s % 4)));
                @(negedge clk);
            end
        end

        // R2, R3, R4, R5, R6: table of frames
        for (int i = 0; i < 6; i++) begin
            set_frame(VEC[i]);
            pulse_load();
            wait_valid(lat);
            chk("R5 valid seen", 32'(valid_o), 32'h1);
            chk("R5 latency low bound", 32'(lat >= CYC + 1), 32'h1);
            chk("R5 latency high bound", 32'(lat <= 2 * CYC), 32'h1);
            chk("R2 R3 freq word", 32'(freq_o), 32'(VEC[i][15:3]));
            chk("R3 mode", 32'(mode_o), 32'(VEC[i][2:0]));
            chk("R4 fm flag", 32'(fm_o), 32'(VEC[i][2:0] == 3'b001));
            @(negedge clk);
            chk("R6 valid single clock", 32'(valid_o), 32'h0);
        end

        // R7: lines change, no load edge
        keep_f = freq_o;
        keep_m = mode_o;
        set_frame({1'b1, 4'd4, 4'd4, 4'd4, 3'b111});
        saw = 1'b0;
        for (int k = 0; k < 3 * CYC; k++) begin
            @(negedge clk);
            if (valid_o) saw = 1'b1;
            if (k == CYC + 3) set_frame({1'b0, 4'd2, 4'd1, 4'd7, 3'b011});
        end
        chk("R7 no valid", 32'(saw), 32'h0);
        chk("R7 freq held", 32'(freq_o), 32'(keep_f));
        chk("R7 mode held", 32'(mode_o), 32'(keep_m));

        // R10: rising edge and held-high load do not arm
        set_frame({1'b0, 4'd9, 4'd1, 4'd3, 3'b001});
        @(negedge clk) ld = 1'b1;
        saw = 1'b0;
        for (int k = 0; k < 3 * CYC; k++) begin
            @(negedge clk);
            if (valid_o) saw = 1'b1;
        end
        chk("R10 held high no valid", 32'(saw), 32'h0);
        chk("R10 freq held", 32'(freq_o), 32'(keep_f));
        ld = 1'b0;
        @(negedge clk);
        wait_valid(lat);
        chk("R10 release arms", 32'(freq_o), 32'h0913);

        // R8: second load edge inside a collection
        set_frame({1'b0, 4'd1, 4'd1, 4'd1, 3'b010});
        wait_slot_entry(4'b1000);
        ld = 1'b1;
        @(negedge clk) ld = 1'b0;
        wait_slot_entry(4'b0100);
        set_frame({1'b1, 4'd0, 4'd6, 4'd5, 3'b001});
        pulse_load();
        vcount = 0;
        for (int k = 0; k < 3 * CYC; k++) begin
            if (valid_o) vcount++;
            @(negedge clk);
        end
        chk("R8 one publish", 32'(vcount), 32'h1);
        chk("R8 restarted word", 32'(freq_o), 32'h1065);
        chk("R8 restarted fm", 32'(fm_o), 32'h1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule